// File: doc/BRIEF.md
# Flash Controller Register Front-End

This block sits between a simple CPU register bus and a small behavioural model of an embedded flash array. Software unlocks its control register by writing two fixed key words, in order, to a key register. It then selects an operation. A page erase is started by one control write. A 64-bit program is started by two ordered 32-bit writes into the flash address window. While an operation runs the block reports busy. When the operation ends it reports completion or an error through a status register whose sticky flags are cleared by writing 1 to them.

The address map has two halves, selected by the top address bit. With that bit at 0 the bus reaches the registers: key at byte offset 0x0, control at 0x4, status at 0x8. With that bit at 1 the bus reaches the flash bytes directly, and reads return the stored words. The array holds `NUM_PAGES` pages of `PAGE_BYTES` bytes. Erase and program take fixed cycle counts set by parameters.

Top module: `nvm_ctrl`

## Requirements
- R1: After reset the control register reads locked (bit 31 = 1, all other bits 0), the status register reads 0, and every flash word reads 0xFFFFFFFF.
- R2: Writing `KEY_A` and then `KEY_B` to the key register clears the lock. A wrong value, or the keys in the wrong order, leaves the block locked and restarts the sequence.
- R3: A control write with bit 31 set relocks the block and changes nothing else. After that, only a complete new key sequence unlocks it; `KEY_B` on its own does not.
- R4: A control write while the block is locked changes no control field and sets the sequence-error flag (status bit 3).
- R5: A control write with erase enable (bit 1) = 1, program enable (bit 0) = 0, start (bit 2) = 1 and a page number in bits [15:8] holds busy (status bit 0) for exactly `ERASE_CYC` cycles. It then sets every word of that page to 0xFFFFFFFF, leaves other pages untouched, and sets the done flag (status bit 2).
- R6: An erase start whose page number is `NUM_PAGES` or above sets the page-error flag (status bit 5), does not go busy, and erases nothing.
- R7: With program enable set, a write of the low word at an 8-byte-aligned flash address followed by a write of the high word at that address + 4 holds busy for exactly `PROG_CYC` cycles. It then stores the double word and sets done.
- R8: If the target double word is not all ones when the program ends, busy still clears. The program-error flag (status bit 4) is set, done is not set, and the array is left unchanged.
- R9: A flash write that is not 4-byte aligned, a high-word write with no matching preceding low-word write, or any flash write while program enable is 0, sets the sequence-error flag and starts nothing.
- R10: An accepted control write sets the configuration-busy flag (status bit 1) for `CFG_CYC` cycles. A control write during that time is ignored and sets the sequence-error flag.
- R11: A control write while an operation is busy is ignored and sets the sequence-error flag.
- R12: Status bits 2 to 5 are cleared by writing 1 to them. Writing 0 to a status bit leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access valid this cycle |
| we_i | input | 1 | Write when 1 (with req_i) |
| addr_i | input | AW (15) | Byte address; top bit selects the flash window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |

## Verification
The bench targets the edges of the key sequencing: a repeated first key and a lone second key must both leave the block locked. A design that only compared the last written value would unlock on them. It counts busy cycles for erase and program exactly, so an off-by-one in the latency counter shows up as a cycle count one too high or one too low. It programs over a word that is not blank to confirm that busy still drops, that the error flag is set without done, and that the old data survives. A design that ANDed the new data in anyway would corrupt that word. It also issues a control write one cycle after an accepted one, another during an erase, and an erase to a page beyond the array. A design that lacked the configuration-busy gate, the busy gate or the page range check would accept the write, reload the fields or wipe memory.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef enum logic [1:0] {
    REG_KEY  = 2'd0,
    REG_CTRL = 2'd1,
    REG_STAT = 2'd2
  } reg_sel_e;

  localparam int CB_PROG  = 0;
  localparam int CB_ERASE = 1;
  localparam int CB_START = 2;
  localparam int CB_LOCK  = 31;

  localparam int SB_DONE   = 2;
  localparam int SB_SEQ    = 3;
  localparam int SB_PERR   = 4;
  localparam int SB_PGERR  = 5;
endpackage

// File: rtl/nvm_keygate.sv
module nvm_keygate #(
  parameter logic [31:0] KEY_A = 32'h3C5A_96E1,
  parameter logic [31:0] KEY_B = 32'hC3A5_691E
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        key_wr_i,
  input  logic [31:0] key_i,
  input  logic        relock_i,
  output logic        locked_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_o <= 1'b1;
      armed_q  <= 1'b0;
    end else if (relock_i) begin
      locked_o <= 1'b1;
      armed_q  <= 1'b0;
    end else if (key_wr_i && locked_o) begin
      if (!armed_q && key_i == KEY_A) begin
        armed_q <= 1'b1;
      end else if (armed_q && key_i == KEY_B) begin
        armed_q  <= 1'b0;
        locked_o <= 1'b0;
      end else begin
        armed_q <= 1'b0;  // any mismatch restarts the sequence
      end
    end
  end
endmodule

// File: rtl/nvm_seq.sv
module nvm_seq #(
  parameter int ERASE_CYC = 20,
  parameter int PROG_CYC  = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_erase_i,
  input  logic go_prog_i,
  input  logic blank_i,
  output logic busy_o,
  output logic erase_fire_o,
  output logic prog_fire_o,
  output logic prog_fail_o
);
  localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             is_prog_q;
  logic             finish;

  assign finish = busy_o && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o    <= 1'b0;
      cnt_q     <= '0;
      is_prog_q <= 1'b0;
    end else if (finish) begin
      busy_o <= 1'b0;
    end else if (busy_o) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (go_erase_i) begin
      busy_o    <= 1'b1;
      is_prog_q <= 1'b0;
      cnt_q     <= CNT_W'(ERASE_CYC - 1);
    end else if (go_prog_i) begin
      busy_o    <= 1'b1;
      is_prog_q <= 1'b1;
      cnt_q     <= CNT_W'(PROG_CYC - 1);
    end
  end

  assign erase_fire_o = finish && !is_prog_q;
  assign prog_fire_o  = finish && is_prog_q && blank_i;
  assign prog_fail_o  = finish && is_prog_q && !blank_i;
endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
  parameter int NUM_PAGES   = 4,
  parameter int DW_PER_PAGE = 512,
  localparam int NUM_DW     = NUM_PAGES * DW_PER_PAGE,
  localparam int IDX_W      = $clog2(NUM_DW),
  localparam int PG_W       = $clog2(NUM_PAGES),
  localparam int OFS_W      = $clog2(DW_PER_PAGE)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             erase_i,
  input  logic [PG_W-1:0]  erase_page_i,
  input  logic             prog_i,
  input  logic [IDX_W-1:0] prog_idx_i,
  input  logic [63:0]      prog_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [63:0]      rd_data_o,
  output logic             blank_o
);
  logic [63:0] mem_q [NUM_DW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_DW; i++) mem_q[i] <= '1;
    end else begin
      if (erase_i) begin
        for (int j = 0; j < DW_PER_PAGE; j++) mem_q[{erase_page_i, OFS_W'(j)}] <= '1;
      end
      if (prog_i) mem_q[prog_idx_i] <= mem_q[prog_idx_i] & prog_data_i;
    end
  end

  assign blank_o   = &mem_q[prog_idx_i];
  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
  import nvm_pkg::*;
#(
  parameter int          PAGE_BYTES = 4096,
  parameter int          NUM_PAGES  = 4,
  parameter int          ERASE_CYC  = 20,
  parameter int          PROG_CYC   = 6,
  parameter int          CFG_CYC    = 2,
  parameter logic [31:0] KEY_A      = 32'h3C5A_96E1,
  parameter logic [31:0] KEY_B      = 32'hC3A5_691E,
  localparam int DW_PER_PAGE = PAGE_BYTES / 8,
  localparam int FA_W        = $clog2(PAGE_BYTES * NUM_PAGES),
  localparam int AW          = FA_W + 1,
  localparam int IDX_W       = FA_W - 3,
  localparam int PG_W        = $clog2(NUM_PAGES),
  localparam int PF_W        = 8,
  localparam int CFG_W       = $clog2(CFG_CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o
);
  logic wr, in_flash, key_wr, ctrl_wr, stat_wr, flash_wr;
  logic [IDX_W-1:0] f_idx;
  logic f_hi, f_mis;

  assign wr       = req_i && we_i;
  assign in_flash = addr_i[AW-1];
  assign key_wr   = wr && !in_flash && (addr_i[3:2] == REG_KEY);
  assign ctrl_wr  = wr && !in_flash && (addr_i[3:2] == REG_CTRL);
  assign stat_wr  = wr && !in_flash && (addr_i[3:2] == REG_STAT);
  assign flash_wr = wr && in_flash;
  assign f_idx    = addr_i[FA_W-1:3];
  assign f_hi     = addr_i[2];
  assign f_mis    = |addr_i[1:0];

  logic locked, busy, cfg_busy;
  logic [CFG_W-1:0] cfg_cnt_q;
  logic prog_en_q, erase_en_q;
  logic [PF_W-1:0] page_q;
  logic done_q, seq_err_q, prog_err_q, page_err_q;
  logic pend_q;
  logic [IDX_W-1:0] lo_idx_q, prog_idx_q;
  logic [31:0] lo_q;
  logic [63:0] prog_data_q;
  logic erase_fire, prog_fire, prog_fail, blank;
  logic [63:0] rd_dw;

  assign cfg_busy = (cfg_cnt_q != '0);

  logic ctrl_ok, relock, ctrl_load, start_req, start_good, page_bad;
  logic go_erase, fw_ok, lo_wr, go_prog, set_seq;

  always_comb begin
    ctrl_ok    = ctrl_wr && !locked && !busy && !cfg_busy;
    relock     = ctrl_ok && wdata_i[CB_LOCK];
    ctrl_load  = ctrl_ok && !wdata_i[CB_LOCK];
    start_req  = ctrl_load && wdata_i[CB_START];
    start_good = start_req && wdata_i[CB_ERASE] && !wdata_i[CB_PROG];
    page_bad   = wdata_i[15:8] >= PF_W'(NUM_PAGES);
    go_erase   = start_good && !page_bad;
    fw_ok      = flash_wr && !locked && prog_en_q && !busy && !f_mis;
    lo_wr      = fw_ok && !f_hi;
    go_prog    = fw_ok && f_hi && pend_q && (f_idx == lo_idx_q);
    set_seq    = (ctrl_wr && !ctrl_ok) || (start_req && !start_good) ||
                 (flash_wr && !lo_wr && !go_prog);
  end

  nvm_keygate #(.KEY_A(KEY_A), .KEY_B(KEY_B)) u_keygate (
    .clk_i, .rst_ni,
    .key_wr_i (key_wr),
    .key_i    (wdata_i),
    .relock_i (relock),
    .locked_o (locked)
  );

  nvm_seq #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_seq (
    .clk_i, .rst_ni,
    .go_erase_i   (go_erase),
    .go_prog_i    (go_prog),
    .blank_i      (blank),
    .busy_o       (busy),
    .erase_fire_o (erase_fire),
    .prog_fire_o  (prog_fire),
    .prog_fail_o  (prog_fail)
  );

  nvm_array #(.NUM_PAGES(NUM_PAGES), .DW_PER_PAGE(DW_PER_PAGE)) u_array (
    .clk_i, .rst_ni,
    .erase_i      (erase_fire),
    .erase_page_i (page_q[PG_W-1:0]),
    .prog_i       (prog_fire),
    .prog_idx_i   (prog_idx_q),
    .prog_data_i  (prog_data_q),
    .rd_idx_i     (f_idx),
    .rd_data_o    (rd_dw),
    .blank_o      (blank)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_cnt_q   <= '0;
      prog_en_q   <= 1'b0;
      erase_en_q  <= 1'b0;
      page_q      <= '0;
      pend_q      <= 1'b0;
      lo_idx_q    <= '0;
      lo_q        <= '0;
      prog_idx_q  <= '0;
      prog_data_q <= '0;
      done_q      <= 1'b0;
      seq_err_q   <= 1'b0;
      prog_err_q  <= 1'b0;
      page_err_q  <= 1'b0;
    end else begin
      if (ctrl_ok) cfg_cnt_q <= CFG_W'(CFG_CYC);
      else if (cfg_busy) cfg_cnt_q <= cfg_cnt_q - 1'b1;

      if (ctrl_load) begin
        prog_en_q  <= wdata_i[CB_PROG];
        erase_en_q <= wdata_i[CB_ERASE];
        page_q     <= wdata_i[15:8];
      end

      if (flash_wr) pend_q <= lo_wr;
      if (lo_wr) begin
        lo_idx_q <= f_idx;
        lo_q     <= wdata_i;
      end
      if (go_prog) begin
        prog_idx_q  <= f_idx;
        prog_data_q <= {wdata_i, lo_q};
      end

      // set wins over a same-cycle clear
      done_q     <= (done_q     & !(stat_wr && wdata_i[SB_DONE]))  | erase_fire | prog_fire;
      seq_err_q  <= (seq_err_q  & !(stat_wr && wdata_i[SB_SEQ]))   | set_seq;
      prog_err_q <= (prog_err_q & !(stat_wr && wdata_i[SB_PERR]))  | prog_fail;
      page_err_q <= (page_err_q & !(stat_wr && wdata_i[SB_PGERR])) | (start_good && page_bad);
    end
  end

  always_comb begin
    rdata_o = '0;
    if (in_flash) begin
      rdata_o = f_hi ? rd_dw[63:32] : rd_dw[31:0];
    end else begin
      case (addr_i[3:2])
        REG_CTRL: rdata_o = {locked, 15'b0, page_q, 6'b0, erase_en_q, prog_en_q};
        REG_STAT: rdata_o = {26'b0, page_err_q, prog_err_q, seq_err_q, done_q, cfg_busy, busy};
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/nvm_ctrl_chk.sv
module nvm_ctrl_chk #(
  parameter int          NUM_PAGES = 4,
  parameter logic [31:0] KEY_B     = 32'hC3A5_691E
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ctrl_wr_i,
  input logic        key_wr_i,
  input logic [31:0] wdata_i,
  input logic        locked_i,
  input logic        busy_i,
  input logic        cfg_busy_i,
  input logic        seq_err_i,
  input logic        done_i,
  input logic        page_err_i
);
  assert_unlock_key_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_i) |-> $past(key_wr_i && wdata_i == KEY_B));

  assert_relock_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i && !locked_i && !busy_i && !cfg_busy_i && wdata_i[31]) |=> locked_i);

  assert_locked_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i && locked_i) |=> seq_err_i);

  assert_done_at_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> $fell(busy_i));

  assert_bad_page_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i && !locked_i && !busy_i && !cfg_busy_i && !wdata_i[31] && wdata_i[2] &&
     wdata_i[1] && !wdata_i[0] && (wdata_i[15:8] >= 8'(NUM_PAGES)))
    |=> (!busy_i && page_err_i));

  assert_cfg_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i && cfg_busy_i) |=> seq_err_i);

  assert_busy_gate_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i && busy_i) |=> seq_err_i);
endmodule

bind nvm_ctrl nvm_ctrl_chk #(.NUM_PAGES(NUM_PAGES), .KEY_B(KEY_B)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ctrl_wr_i  (ctrl_wr),
  .key_wr_i   (key_wr),
  .wdata_i    (wdata_i),
  .locked_i   (locked),
  .busy_i     (busy),
  .cfg_busy_i (cfg_busy),
  .seq_err_i  (seq_err_q),
  .done_i     (done_q),
  .page_err_i (page_err_q)
);

// File: tb/nvm_ctrl_test.sv
module nvm_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int ERASE_CYC  = 20;
  localparam int PROG_CYC   = 6;
  localparam int CFG_CYC    = 2;
  localparam int AW         = 15;
  localparam logic [31:0] KA = 32'h3C5A_96E1;
  localparam logic [31:0] KB = 32'hC3A5_691E;
  localparam logic [AW-1:0] A_KEY = 15'h0000, A_CTRL = 15'h0004, A_STAT = 15'h0008;

  logic clk = 1'b0, rst_ni = 1'b0, req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_ctrl #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC), .CFG_CYC(CFG_CYC),
             .KEY_A(KA), .KEY_B(KB)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata));

  typedef struct packed {
    logic          rd;
    logic [AW-1:0] a;
    logic [31:0]   d;
    logic [3:0]    rq;
    logic [3:0]    idle;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{1'b1, A_CTRL, 32'h8000_0000, 4'd1, 4'd0},  // R1 locked
    '{1'b1, A_STAT, 32'h0,         4'd1, 4'd0},  // R1 status clear
    '{1'b1, 15'h4000, 32'hFFFF_FFFF, 4'd1, 4'd0},// R1 erased
    '{1'b1, 15'h7FFC, 32'hFFFF_FFFF, 4'd1, 4'd0},
    '{1'b0, A_KEY, KA, 4'd2, 4'd0},
    '{1'b0, A_KEY, KA, 4'd2, 4'd0},
    '{1'b0, A_KEY, KB, 4'd2, 4'd0},
    '{1'b1, A_CTRL, 32'h8000_0000, 4'd2, 4'd0},  // R2 bad order
    '{1'b0, A_CTRL, 32'h0000_0001, 4'd4, 4'd0},
    '{1'b1, A_STAT, 32'h0000_0008, 4'd4, 4'd0},  // R4
    '{1'b1, A_CTRL, 32'h8000_0000, 4'd4, 4'd0},
    '{1'b0, A_STAT, 32'h0,         4'd12, 4'd0},
    '{1'b1, A_STAT, 32'h0000_0008, 4'd12, 4'd0}, // R12 write 0 keeps
    '{1'b0, A_STAT, 32'h0000_0008, 4'd12, 4'd0},
    '{1'b1, A_STAT, 32'h0,         4'd12, 4'd0}, // R12 w1c
    '{1'b0, A_KEY, KA, 4'd2, 4'd0},
    '{1'b0, A_KEY, KB, 4'd2, 4'd0},
    '{1'b1, A_CTRL, 32'h0,         4'd2, 4'd0},  // R2 unlocked
    '{1'b0, A_CTRL, 32'h8000_0000, 4'd3, 4'd3},
    '{1'b1, A_CTRL, 32'h8000_0000, 4'd3, 4'd0},  // R3 relocked
    '{1'b0, A_KEY, KB, 4'd3, 4'd0},
    '{1'b1, A_CTRL, 32'h8000_0000, 4'd3, 4'd0},  // R3 lone second key
    '{1'b0, A_KEY, KA, 4'd2, 4'd0},
    '{1'b0, A_KEY, KB, 4'd2, 4'd0},
    '{1'b1, A_CTRL, 32'h0,         4'd2, 4'd0}
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string rq);
    addr = a;
    #1;
    chk(rq, rdata, exp);
    @(negedge clk);
  endtask

  task automatic wait_busy(output int n);
    n = 0;
    addr = A_STAT;
    #1;
    while (rdata[0]) begin
      n++;
      @(negedge clk);
      #1;
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].rd) rd(VEC[i].a, VEC[i].d, $sformatf("R%0d vec %0d", VEC[i].rq, i));
      else wr(VEC[i].a, VEC[i].d);
      repeat (int'(VEC[i].idle)) @(negedge clk);
    end

    // R10 configuration-busy gate
    wr(A_CTRL, 32'h1);
    rd(A_STAT, 32'h2, "R10 cfg busy");
    wr(A_CTRL, 32'h0);
    rd(A_STAT, 32'h8, "R10 rejected");
    rd(A_CTRL, 32'h1, "R10 fields kept");
    wr(A_STAT, 32'h8);

    // R7 program two double words
    wr(15'h4008, 32'h0F0F_0F0F);
    wr(15'h400C, 32'h00FF_00FF);
    wait_busy(n);
    chk("R7 latency", n, PROG_CYC);
    wr(15'h5010, 32'h1234_5678);
    wr(15'h5014, 32'h9ABC_DEF0);
    wait_busy(n);
    chk("R7 latency", n, PROG_CYC);
    rd(A_STAT, 32'h4, "R7 done");
    rd(15'h5010, 32'h1234_5678, "R7 low");
    rd(15'h5014, 32'h9ABC_DEF0, "R7 high");
    wr(A_STAT, 32'h4);

    // R8 program over non-blank word
    wr(15'h5010, 32'h0);
    wr(15'h5014, 32'h0);
    wait_busy(n);
    chk("R8 latency", n, PROG_CYC);
    rd(A_STAT, 32'h10, "R8 error");
    rd(15'h5010, 32'h1234_5678, "R8 unchanged");
    wr(A_STAT, 32'h10);

    // R9 sequence errors on flash writes
    wr(15'h5016, 32'h1);
    rd(A_STAT, 32'h8, "R9 misaligned");
    wr(A_STAT, 32'h8);
    wr(15'h501C, 32'h1);
    rd(A_STAT, 32'h8, "R9 high alone");
    wr(A_STAT, 32'h8);
    wr(15'h5020, 32'hAAAA_AAAA);
    wr(15'h502C, 32'hBBBB_BBBB);
    rd(A_STAT, 32'h8, "R9 other dword");
    rd(15'h5020, 32'hFFFF_FFFF, "R9 no write");
    wr(A_STAT, 32'h8);

    // R5 erase page 1
    wr(A_CTRL, 32'h0000_0106);
    wait_busy(n);
    chk("R5 latency", n, ERASE_CYC);
    rd(A_STAT, 32'h4, "R5 done");
    rd(15'h5010, 32'hFFFF_FFFF, "R5 erased lo");
    rd(15'h5014, 32'hFFFF_FFFF, "R5 erased hi");
    rd(15'h4008, 32'h0F0F_0F0F, "R5 other page");
    wr(A_STAT, 32'h4);

    // R11 control write while busy
    wr(A_CTRL, 32'h0000_0206);
    wr(A_CTRL, 32'h0000_0001);
    wait_busy(n);
    chk("R11 latency", n, ERASE_CYC - 1);
    rd(A_STAT, 32'hC, "R11 status");
    rd(A_CTRL, 32'h0000_0202, "R11 fields");
    wr(A_STAT, 32'hC);

    // R6 page out of range
    wr(A_CTRL, 32'h0000_0506);
    rd(A_STAT, 32'h22, "R6 page error");
    rd(15'h400C, 32'h00FF_00FF, "R6 nothing erased");
    wr(A_STAT, 32'h20);

    // R9 flash write with program disabled
    wr(15'h4020, 32'h1);
    rd(A_STAT, 32'h8, "R9 prog disabled");
    rd(15'h4020, 32'hFFFF_FFFF, "R9 prog disabled data");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule